// File: doc/BRIEF.md
# Sticky Interrupt Status Latch for a Dual Card Interface

This block holds the event and fault flags of a two-slot smart-card interface controller. Supply and reset faults on each card, changes on each card-presence input, overheating, supply supervisor events and changes on an auxiliary input are each caught in a sticky status bit. The bits stay set until the host reads the status word, so a short event is never missed. An active-low interrupt line tells the host that at least one flag needs attention.

Any fault or event that forces an emergency shutdown of a card also gives a one-cycle pulse. The surrounding control register uses this pulse to clear its card-activation bit. The supervisor flag follows its own rules. It is set out of reset and on every supply drop-out. While the supervisor alarm pulse is active, it holds the interrupt low. A read clears it only when the read comes after the alarm pulse has ended. The block also watches host access spacing. A status read, or an activation write, that comes too soon after the previous status read raises an error pulse.

All inputs are taken as already synchronous to `clk_i`. A status read is one cycle of `rd_stb_i`, and the host samples `status_o` in that same cycle.

Top module: `irq_status_latch`

## Requirements
- R1: After reset, `status_o` reads 0x10, with only the supervisor bit set, and `start_clr_o` and `timing_err_o` are low. Bit layout: 7 auxiliary change, 6 card-2 fault, 5 card-1 fault, 4 supervisor, 3 card-2 presence change, 2 card-1 presence change, 1 unused, 0 overheating.
- R2: A card's fault bit (5 or 6) sets at the clock edge after either its supply fault input or its reset fault input is high. It stays set until a read clears it.
- R3: A presence bit (2 or 3) sets at the clock edge after a rising or a falling change on its presence input. The level seen when reset is released does not set it.
- R4: `irq_no` is low whenever any of bits 6, 5, 3, 2 or 0 is set, or bit 7 is set with `aux_irq_dis_i` low, or `alarm_i` is high. Otherwise it is high, so a set supervisor bit alone does not hold it low.
- R5: A read clears bits 6, 5, 3, 2 and 0 at the next edge. It clears bit 7 only when `aux_irq_dis_i` is low. With the auxiliary interrupt disabled, bit 7 survives the read.
- R6: `supply_drop_i` sets bit 4. A read while `alarm_i` is high leaves bit 4 set. A read while `alarm_i` is low clears it.
- R7: A set condition in the same cycle as a clearing read leaves the bit set.
- R8: `start_clr_o` is high for the cycle after any set condition of bits 6, 5, 4, 3, 2 or 0. An auxiliary change alone never raises it.
- R9: `timing_err_o` is high for one cycle after a read or an activation write that comes fewer than `GAP_CYC` cycles after the previous read. At exactly `GAP_CYC` cycles, or before any read has happened since reset, it stays low.
- R10: Bit 1 of `status_o` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| c1_vcc_flt_i | input | 1 | Card 1 supply pin fault |
| c1_rst_flt_i | input | 1 | Card 1 reset pin fault |
| c2_vcc_flt_i | input | 1 | Card 2 supply pin fault |
| c2_rst_flt_i | input | 1 | Card 2 reset pin fault |
| pres1_i | input | 1 | Card 1 presence level |
| pres2_i | input | 1 | Card 2 presence level |
| overheat_i | input | 1 | Overheating detected |
| supply_drop_i | input | 1 | Supervisor supply drop-out event |
| alarm_i | input | 1 | Supervisor alarm pulse active |
| aux_i | input | 1 | Auxiliary interrupt input level |
| aux_irq_dis_i | input | 1 | Disable auxiliary interrupt and its read clear |
| rd_stb_i | input | 1 | Status read strobe, one cycle per read |
| act_wr_i | input | 1 | Activation write to the control register |
| status_o | output | 8 | Sticky status word |
| irq_no | output | 1 | Interrupt, active low |
| start_clr_o | output | 1 | Pulse that clears the activation bit |
| timing_err_o | output | 1 | Access spacing violation pulse |

## Verification
The assertions assume that `rd_stb_i` stands for one read per high cycle. They also assume that fault and event inputs are already clean and synchronous, so a level that is high for one cycle counts as a real event. The overheating and supervisor properties look at the cycle after a read and allow for set conditions present in that cycle. They therefore need no spacing assumption. The directed stimulus drives every input on the falling edge, and apart from the deliberate spacing tests it keeps reads at least `GAP_CYC` cycles apart. This way a spurious spacing error cannot hide a wrong status value.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int ST_W    = 8;
  localparam int B_OT    = 0;
  localparam int B_PRES1 = 2;
  localparam int B_PRES2 = 3;
  localparam int B_SUP   = 4;
  localparam int B_FLT1  = 5;
  localparam int B_FLT2  = 6;
  localparam int B_AUX   = 7;
  // bits that always drive the interrupt and always clear on read
  localparam logic [ST_W-1:0] IRQ_MASK   = 8'h6D;
  // bits whose set condition forces emergency deactivation
  localparam logic [ST_W-1:0] EMERG_MASK = 8'h7D;
  localparam logic [ST_W-1:0] ST_RST     = 8'h10;
endpackage

// File: rtl/level_change_det.sv
module level_change_det #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] prev_q;
  logic         armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= lvl_i;
      armed_q <= 1'b1;
    end
  end

  // first cycle after reset only captures the level
  for (genvar i = 0; i < W; i++) begin : g_det
    assign chg_o[i] = armed_q & (lvl_i[i] ^ prev_q[i]);
  end
endmodule

// File: rtl/sticky_bank.sv
module sticky_bank #(
  parameter int          W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[i] <= RST_VAL[i];
      else         q[i] <= set_i[i] | (q[i] & ~clr_i[i]); // set wins
    end
  end

  assign q_o = q;
endmodule

// File: rtl/read_gap_mon.sv
module read_gap_mon #(
  parameter int GAP_CYC = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  logic wr_i,
  output logic err_o
);
  localparam int CW = $clog2(GAP_CYC + 1);
  localparam logic [CW-1:0] GAP = CW'(GAP_CYC);

  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          err_q;
  logic          viol;

  assign viol = armed_q & (rd_i | wr_i) & (cnt_q < GAP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= viol;
      if (rd_i) begin
        cnt_q   <= CW'(1);
        armed_q <= 1'b1;
      end else if (cnt_q < GAP) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/irq_status_latch.sv
module irq_status_latch
  import irq_status_pkg::*;
#(
  parameter int GAP_CYC = 200
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            c1_vcc_flt_i,
  input  logic            c1_rst_flt_i,
  input  logic            c2_vcc_flt_i,
  input  logic            c2_rst_flt_i,
  input  logic            pres1_i,
  input  logic            pres2_i,
  input  logic            overheat_i,
  input  logic            supply_drop_i,
  input  logic            alarm_i,
  input  logic            aux_i,
  input  logic            aux_irq_dis_i,
  input  logic            rd_stb_i,
  input  logic            act_wr_i,
  output logic [ST_W-1:0] status_o,
  output logic            irq_no,
  output logic            start_clr_o,
  output logic            timing_err_o
);
  logic [2:0]      chg;
  logic [ST_W-1:0] set_v;
  logic [ST_W-1:0] clr_v;
  logic [ST_W-1:0] st_q;
  logic            start_clr_q;

  level_change_det #(.W(3)) u_chg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({aux_i, pres2_i, pres1_i}),
    .chg_o  (chg)
  );

  always_comb begin
    set_v          = '0;
    set_v[B_OT]    = overheat_i;
    set_v[B_PRES1] = chg[0];
    set_v[B_PRES2] = chg[1];
    set_v[B_SUP]   = supply_drop_i;
    set_v[B_FLT1]  = c1_vcc_flt_i | c1_rst_flt_i;
    set_v[B_FLT2]  = c2_vcc_flt_i | c2_rst_flt_i;
    set_v[B_AUX]   = chg[2];
  end

  always_comb begin
    clr_v = '0;
    if (rd_stb_i) begin
      clr_v        = IRQ_MASK;
      clr_v[B_SUP] = ~alarm_i;
      clr_v[B_AUX] = ~aux_irq_dis_i;
    end
  end

  sticky_bank #(.W(ST_W), .RST_VAL(ST_RST)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .q_o    (st_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_clr_q <= 1'b0;
    else         start_clr_q <= |(set_v & EMERG_MASK);
  end

  read_gap_mon #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd_stb_i),
    .wr_i   (act_wr_i),
    .err_o  (timing_err_o)
  );

  assign status_o    = st_q;
  assign start_clr_o = start_clr_q;
  assign irq_no      = ~((|(st_q & IRQ_MASK)) | (st_q[B_AUX] & ~aux_irq_dis_i) | alarm_i);
endmodule

// File: rtl/irq_status_latch_chk.sv
module irq_status_latch_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic overheat_i,
  input logic supply_drop_i,
  input logic alarm_i,
  input logic rd_stb_i,
  input logic act_wr_i,
  input logic ot_bit_i,
  input logic sup_bit_i,
  input logic irq_no,
  input logic start_clr_o,
  input logic timing_err_o
);
  // R7
  ot_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overheat_i |=> ot_bit_i);
  // R5
  ot_read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && !overheat_i) |=> !ot_bit_i);
  // R6
  sup_hold_alarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sup_bit_i && rd_stb_i && alarm_i) |=> sup_bit_i);
  // R6
  sup_read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && !alarm_i && !supply_drop_i) |=> !sup_bit_i);
  // R4
  alarm_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_i |-> !irq_no);
  // R8
  emerg_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overheat_i || supply_drop_i) |=> start_clr_o);
  // R9
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timing_err_o |-> $past(rd_stb_i || act_wr_i));
endmodule

bind irq_status_latch irq_status_latch_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .overheat_i    (overheat_i),
  .supply_drop_i (supply_drop_i),
  .alarm_i       (alarm_i),
  .rd_stb_i      (rd_stb_i),
  .act_wr_i      (act_wr_i),
  .ot_bit_i      (status_o[0]),
  .sup_bit_i     (status_o[4]),
  .irq_no        (irq_no),
  .start_clr_o   (start_clr_o),
  .timing_err_o  (timing_err_o)
);

// File: tb/irq_status_latch_tb.sv
module irq_status_latch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic c1v = 0, c1r = 0, c2v = 0, c2r = 0, p1 = 0, p2 = 0, ot = 0;
  logic sdrop = 0, alarm = 1, aux = 0, aux_dis = 0, rd = 0, awr = 0;
  logic [7:0] st;
  logic irq_n, sclr, terr;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_latch #(.GAP_CYC(GAP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .c1_vcc_flt_i(c1v), .c1_rst_flt_i(c1r), .c2_vcc_flt_i(c2v), .c2_rst_flt_i(c2r),
    .pres1_i(p1), .pres2_i(p2), .overheat_i(ot), .supply_drop_i(sdrop),
    .alarm_i(alarm), .aux_i(aux), .aux_irq_dis_i(aux_dis),
    .rd_stb_i(rd), .act_wr_i(awr),
    .status_o(st), .irq_no(irq_n), .start_clr_o(sclr), .timing_err_o(terr)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one-cycle read; returns at the negedge after the clearing edge
  task automatic do_read();
    rd = 1; tick(); rd = 0;
  endtask

  task automatic t_reset();
    chk("R1 status", st, 8'h10);
    chk("R1 start_clr", {7'd0, sclr}, 8'd0);
    chk("R1 timing_err", {7'd0, terr}, 8'd0);
    chk("R4 alarm holds irq", {7'd0, irq_n}, 8'd0);
    awr = 1; tick(); awr = 0;
    chk("R9 no error before first read", {7'd0, terr}, 8'd0);
    alarm = 0; tick();
    chk("R4 irq high with only sup", {7'd0, irq_n}, 8'd1);
  endtask

  task automatic t_sup();
    alarm = 1; do_read();
    chk("R6 kept during alarm", st, 8'h10);
    chk("R9 first read clean", {7'd0, terr}, 8'd0);
    tick(GAP); alarm = 0; do_read();
    chk("R6 cleared after alarm", st, 8'h00);
    tick(GAP);
    sdrop = 1; alarm = 1; tick(); sdrop = 0;
    chk("R6 drop sets sup", st, 8'h10);
    chk("R8 sup pulse", {7'd0, sclr}, 8'd1);
    chk("R4 irq during alarm", {7'd0, irq_n}, 8'd0);
    alarm = 0; tick();
    chk("R8 pulse ends", {7'd0, sclr}, 8'd0);
    chk("R4 irq released at alarm end", {7'd0, irq_n}, 8'd1);
    do_read(); chk("R6 cleared", st, 8'h00); tick(GAP);
  endtask

  task automatic t_prot();
    c1v = 1; tick(); c1v = 0;
    chk("R2 card1 supply fault", st, 8'h20);
    chk("R8 fault pulse", {7'd0, sclr}, 8'd1);
    chk("R4 fault irq", {7'd0, irq_n}, 8'd0);
    tick(3); chk("R2 sticky", st, 8'h20);
    do_read(); chk("R5 fault cleared", st, 8'h00);
    chk("R4 irq released", {7'd0, irq_n}, 8'd1);
    tick(GAP);
    c2r = 1; tick(); c2r = 0;
    chk("R2 card2 reset fault", st, 8'h40);
    c1r = 1; tick(); c1r = 0;
    chk("R2 card1 reset fault, R10 bit1 zero", st, 8'h60);
    do_read(); chk("R5 both cleared", st, 8'h00); tick(GAP);
  endtask

  task automatic t_pres();
    p1 = 1; tick();
    chk("R3 rising presence1", st, 8'h04);
    chk("R8 presence pulse", {7'd0, sclr}, 8'd1);
    do_read(); chk("R5 presence cleared", st, 8'h00); tick(GAP);
    p1 = 0; tick();
    chk("R3 falling presence1", st, 8'h04);
    do_read(); tick(GAP);
    p2 = 1; tick();
    chk("R3 rising presence2", st, 8'h08);
    tick(2); chk("R3 steady level no new event", st, 8'h08);
    do_read(); chk("R5 presence2 cleared", st, 8'h00); tick(GAP);
  endtask

  task automatic t_collide();
    ot = 1; rd = 1; tick(); rd = 0; ot = 0;
    chk("R7 set wins over read", st, 8'h01);
    chk("R4 overheat irq", {7'd0, irq_n}, 8'd0);
    tick(GAP); do_read();
    chk("R5 overheat cleared", st, 8'h00); tick(GAP);
  endtask

  task automatic t_aux();
    aux_dis = 1; aux = 1; tick();
    chk("R3 aux change latched", st, 8'h80);
    chk("R8 aux no pulse", {7'd0, sclr}, 8'd0);
    chk("R4 aux disabled no irq", {7'd0, irq_n}, 8'd1);
    do_read(); chk("R5 aux kept while disabled", st, 8'h80);
    aux_dis = 0; #1;
    chk("R4 aux enabled irq", {7'd0, irq_n}, 8'd0);
    tick(GAP); do_read();
    chk("R5 aux cleared", st, 8'h00);
    chk("R4 irq released", {7'd0, irq_n}, 8'd1);
    tick(GAP);
  endtask

  task automatic t_gap();
    do_read(); tick(GAP - 2); do_read();
    chk("R9 read too soon", {7'd0, terr}, 8'd1);
    tick(); chk("R9 error one cycle", {7'd0, terr}, 8'd0);
    tick(GAP - 2); do_read();
    chk("R9 read at limit", {7'd0, terr}, 8'd0);
    tick(GAP - 2); awr = 1; tick(); awr = 0;
    chk("R9 activation too soon", {7'd0, terr}, 8'd1);
    do_read(); tick(GAP - 1); awr = 1; tick(); awr = 0;
    chk("R9 activation at limit", {7'd0, terr}, 8'd0);
  endtask

  initial begin
    fork
      begin
        tick(2); rst_n = 1; tick();
        t_reset(); t_sup(); t_prot(); t_pres(); t_collide(); t_aux(); t_gap();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule